// File: doc/BRIEF.md
# Microcoded I2C Bit Sequencer

This block produces I2C bus waveforms from a table of linked microinstructions. It has no fixed master state machine. A host fills the instruction memory one entry at a time through a single write port. Each entry holds four things: the level of each bus line for one step, a flag that asks for SDA to be sampled, a flag that keeps the sequence running, and the index of the next entry. Start and stop conditions, data bits, acknowledge slots and read bits are all composed by the host from these steps.

After a go pulse the engine runs from a fixed start entry and follows the next-entry links. Each entry is held for a programmable number of clocks, which sets the SCL rate. The engine stops when a link points to an entry whose keep-running flag is clear. Entry 0 is a parking entry: its line levels are driven while the engine is idle. Sampled SDA bits shift into a 32-bit read register, so the last four bytes received stay available and the newest byte sits in the low byte. The pads are open-drain and appear as pull-low enables.

Top module: `i2c_microseq`

## Requirements
- R1: An instruction write (`ins_wr`=1) stores one entry. Its fields in `ins_data` are: target index from bit 18 upward, keep-running flag in bit 13, sample flag in bit 12, inverted SCL in bit 11, inverted SDA in bit 10, and next index in bits 9:0.
- R2: While the engine runs, `scl_oe` equals the stored inverted-SCL bit of the executing entry and `sda_oe` equals its stored inverted-SDA bit. A 1 pulls the line low; a 0 releases it high.
- R3: While idle, the pads follow the levels stored in entry 0.
- R4: A go pulse seen while idle clears `rd_data` and starts execution at entry 1. `busy` rises on the next clock if entry 1 has its keep-running flag set.
- R5: Each entry is executed for `step_div`+1 clocks. The engine then moves to the entry named by the next field.
- R6: When the next field names an entry whose keep-running flag is clear, the engine halts instead of moving. `busy` falls on the clock that ends the last step. If entry 1 itself has the flag clear, a go pulse leaves `busy` low.
- R7: On the final clock of a step with the sample flag set, `rd_data` shifts left by one and `sda_in` enters the LSB. Because of this, the last four bytes read remain, with the last one in bits 7:0. At no other time does `rd_data` change, apart from the clear on go.
- R8: A go pulse while `busy` is high has no effect on the running sequence or on `rd_data`.
- R9: After reset, `busy` is 0, `rd_data` is 0 and both pads are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_wr | input | 1 | Instruction write strobe |
| ins_data | input | 32 | Instruction write word |
| go | input | 1 | Start pulse |
| step_div | input | DIV_W | Clocks per step minus one |
| sda_in | input | 1 | Sensed SDA line level |
| busy | output | 1 | High while the sequence runs |
| rd_data | output | RD_W | Shifted-in read bits |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The go pulse and the first step are one clock apart. `busy` rises, `rd_data` clears and the levels of entry 1 reach the pads on the edge that captures go. After that, each entry's levels stay on the pads for exactly `step_div`+1 clocks. A sampled bit lands in `rd_data` on the edge that ends its step, and `busy` falls on the edge that ends the last step. The bench drives and samples on falling edges. It keeps its own copy of the program and walks it one clock at a time. For every cycle it predicts the pad levels and `busy`, drives `sda_in` from a pattern during sample steps, and compares the halt value of `rd_data` with the pattern bits shifted in.

// File: rtl/i2c_microseq.sv
`timescale 1ns/1ps
module i2c_microseq #(
  parameter int IDX_W     = 10,
  parameter int DIV_W     = 8,
  parameter int RD_W      = 32,
  parameter int START_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_wr,
  input  logic [31:0]      ins_data,
  input  logic             go,
  input  logic [DIV_W-1:0] step_div,
  input  logic             sda_in,
  output logic             busy,
  output logic [RD_W-1:0]  rd_data,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int ENT_W   = IDX_W + 4;
  localparam int IDX_LSB = 18;
  localparam int B_SDA   = IDX_W;
  localparam int B_SCL   = IDX_W + 1;
  localparam int B_RD    = IDX_W + 2;
  localparam int B_RUN   = IDX_W + 3;
  localparam logic [IDX_W-1:0] START = IDX_W'(START_IDX);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] idle_ent;
  logic [IDX_W-1:0] pc;
  logic [DIV_W-1:0] cnt;
  logic             running;

  logic [IDX_W-1:0] wr_idx;
  logic [ENT_W-1:0] wr_ent;
  logic [ENT_W-1:0] cur, nxt, lvl;
  logic             step_end;
  logic             unused_bits;

  assign wr_idx      = ins_data[IDX_LSB +: IDX_W];
  assign wr_ent      = {ins_data[13:10], ins_data[IDX_W-1:0]};
  assign unused_bits = &{1'b0, ins_data[31:IDX_LSB+IDX_W], ins_data[IDX_LSB-1:14]};

  assign cur      = mem[pc];
  assign nxt      = mem[cur[IDX_W-1:0]];
  assign step_end = running && (cnt == step_div);
  assign lvl      = running ? cur : idle_ent;

  always_ff @(posedge clk)
    if (ins_wr) mem[wr_idx] <= wr_ent;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          idle_ent <= '0;
    else if (ins_wr && wr_idx == '0)     idle_ent <= wr_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= START;
      cnt     <= '0;
      rd_data <= '0;
    end else if (go && !running) begin
      running <= mem[START][B_RUN];
      pc      <= START;
      cnt     <= '0;
      rd_data <= '0;
    end else if (step_end) begin
      cnt <= '0;
      if (cur[B_RD]) rd_data <= {rd_data[RD_W-2:0], sda_in};
      if (nxt[B_RUN]) pc <= cur[IDX_W-1:0];
      else            running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy   = running;
  assign scl_oe = lvl[B_SCL];
  assign sda_oe = lvl[B_SDA];
endmodule

// File: rtl/i2c_microseq_chk.sv
`timescale 1ns/1ps
module i2c_microseq_chk #(
  parameter int IDX_W = 10,
  parameter int DIV_W = 8,
  parameter int RD_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic [RD_W-1:0]  rd_data,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] step_div,
  input logic [IDX_W-1:0] pc
);
  AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R4
  AST_GO_CLEARS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (rd_data == '0)); // R4
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != step_div) |=> (busy && $stable(pc))); // R5
  AST_RD_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rd_data) || rd_data[RD_W-1:1] == $past(rd_data[RD_W-2:0]))); // R7
  AST_IDLE_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(rd_data)); // R7
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && cnt != step_div) |=> (busy && $stable(rd_data))); // R8
endmodule

bind i2c_microseq i2c_microseq_chk #(.IDX_W(IDX_W), .DIV_W(DIV_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .rd_data(rd_data),
  .cnt(cnt), .step_div(step_div), .pc(pc)
);

// File: tb/i2c_microseq_test.sv
`timescale 1ns/1ps
module i2c_microseq_test;
  logic        clk = 0, rst_n = 0, ins_wr = 0, go = 0, sda_in = 1;
  logic [31:0] ins_data = '0;
  logic [7:0]  step_div = '0;
  logic        busy, scl_oe, sda_oe;
  logic [31:0] rd_data;

  int total = 0, bad = 0, ptr = 1;
  bit m_run [1024];
  bit m_rd  [1024];
  bit m_scn [1024];
  bit m_sdn [1024];
  int m_nx  [1024];

  i2c_microseq uut (
    .clk(clk), .rst_n(rst_n), .ins_wr(ins_wr), .ins_data(ins_data), .go(go),
    .step_div(step_div), .sda_in(sda_in), .busy(busy), .rd_data(rd_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 field layout: index<<18, run bit13, sample bit12, ~scl bit11, ~sda bit10, next[9:0]
  task automatic emit(input int idx, input bit run, input bit rd, input bit scl, input bit sda, input int nx);
    ins_data = (idx << 18) | (run << 13) | (rd << 12) | ((!scl) << 11) | ((!sda) << 10) | nx;
    ins_wr = 1;
    @(negedge clk);
    ins_wr = 0;
    m_run[idx] = run; m_rd[idx] = rd; m_scn[idx] = !scl; m_sdn[idx] = !sda; m_nx[idx] = nx;
  endtask

  task automatic step(input bit scl, input bit sda, input bit rd);
    emit(ptr, 1, rd, scl, sda, ptr + 1);
    ptr++;
  endtask
  task automatic wbit(input bit d);
    step(0, d, 0); step(1, d, 0); step(0, d, 0);
  endtask
  task automatic rbit();
    step(0, 1, 0); step(1, 1, 0); step(1, 1, 1); step(0, 1, 0);
  endtask
  task automatic wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    wbit(1);
  endtask
  task automatic rbyte(input bit last);
    for (int i = 0; i < 8; i++) rbit();
    wbit(last);
  endtask
  task automatic build(input logic [7:0] addr, input int nrd);
    ptr = 1;
    step(1, 1, 0); step(1, 0, 0); step(0, 0, 0);
    wbyte(addr);
    for (int i = 0; i < nrd; i++) rbyte(i == nrd - 1);
    step(0, 0, 0); step(1, 0, 0);
    emit(ptr, 1, 0, 1, 1, 0);
    ptr++;
  endtask

  task automatic run(input logic [63:0] pat, input int div, input int go_at);
    int pc = 1, k = 0, cyc = 0;
    logic [31:0] exp = '0;
    step_div = 8'(div);
    go = 1;
    @(negedge clk);
    go = 0;
    chk(busy == 1'b1, "R4 busy after go", 64'(busy), 1);
    chk(rd_data == 32'd0, "R4 rd cleared", 64'(rd_data), 0);
    forever begin
      logic b;
      b = pat[63 - (k % 64)];
      for (int c = 0; c <= div; c++) begin
        chk(scl_oe == m_scn[pc], "R1 R2 scl_oe", 64'(scl_oe), 64'(m_scn[pc]));
        chk(sda_oe == m_sdn[pc], "R2 sda_oe", 64'(sda_oe), 64'(m_sdn[pc]));
        chk(busy == 1'b1, "R5 busy held", 64'(busy), 1);
        sda_in = m_rd[pc] ? b : 1'b1;
        go = (cyc == go_at);
        cyc++;
        @(negedge clk);
      end
      go = 0;
      if (m_rd[pc]) begin exp = {exp[30:0], b}; k++; end
      if (!m_run[m_nx[pc]]) break;
      pc = m_nx[pc];
    end
    sda_in = 1;
    chk(busy == 1'b0, "R6 halt", 64'(busy), 0);
    chk(rd_data == exp, "R7 rd_data", 64'(rd_data), 64'(exp));
    chk(scl_oe == m_scn[0] && sda_oe == m_sdn[0], "R3 idle pads", {scl_oe, sda_oe}, {m_scn[0], m_sdn[0]});
    @(negedge clk);
    chk(rd_data == exp, "R7 rd held idle", 64'(rd_data), 64'(exp));
  endtask

  initial begin
    @(negedge clk);
    chk(busy == 0, "R9 busy reset", 64'(busy), 0);
    chk(rd_data == 0, "R9 rd reset", 64'(rd_data), 0);
    chk(scl_oe == 0 && sda_oe == 0, "R9 pads reset", {scl_oe, sda_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    emit(0, 0, 0, 1, 0, 0);
    chk(sda_oe == 1 && scl_oe == 0, "R3 idle sda low", {scl_oe, sda_oe}, 2'b01);
    emit(0, 0, 0, 0, 1, 0);
    chk(sda_oe == 0 && scl_oe == 1, "R3 idle scl low", {scl_oe, sda_oe}, 2'b10);
    emit(0, 0, 0, 1, 1, 0);
    chk(sda_oe == 0 && scl_oe == 0, "R3 idle released", {scl_oe, sda_oe}, 0);

    build(8'hA5, 4);
    run(64'hC3E1_5A96_0000_0000, 0, -1);
    run(64'h1234_5678_0000_0000, 3, -1);
    run(64'h8F01_7EA2_0000_0000, 1, 20);   // R8 go mid-run
    run(64'hFFFF_FFFF_0000_0000, 2, 200);  // R8
    build(8'h3C, 5);
    run(64'h55AA_0FF0_9900_0000, 1, -1);   // R7 last four bytes kept
    build(8'hFF, 1);
    run(64'h0000_0000_0000_0000, 0, 5);

    emit(1, 0, 0, 0, 0, 2);
    go = 1;
    @(negedge clk);
    go = 0;
    chk(busy == 0, "R6 entry1 not running", 64'(busy), 0);
    chk(rd_data == 0, "R4 rd cleared on empty go", 64'(rd_data), 0);
    chk(scl_oe == 0 && sda_oe == 0, "R3 pads after empty go", {scl_oe, sda_oe}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule